// File: doc/BRIEF.md
# Serial Audio Transmitter with Selectable Framing

This block turns parallel PCM words into a serial data stream for an external codec. The codec is the clock master: it supplies the bit clock and the frame sync, and the block samples both in its own system clock domain. The block uses each bit-clock launch edge to decide when a frame begins and when each bit goes out. Software picks one of four framing styles. Two of them put the sync edge one bit ahead of the first data bit, and two put it on the first data bit itself. The sync can be active low or active high. Separate controls invert the sync level and swap the bit-clock edge on which data changes.

A frame holds a programmable number of time slots. Each slot is exactly one word long, and a per-slot mask turns any slot into silence. Words enter through a ready/valid port into a small first-word-fall-through FIFO, which is read at the start of each live slot. If a live slot starts while the FIFO is empty, the block sends zeros and raises a sticky flag. Configuration is latched only while the port enable is low.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset, sd_out is 0, in_ready is 1 and underrun is 0.
- R2: The cfg_* inputs are captured on a clock where cfg_wr is 1 and port_en is 0. A cfg_wr pulse while port_en is 1 has no effect on the transmitted stream.
- R3: With cfg_fmt = 0 (I2S), the sync is active low. When a launch edge first sees the sync go active, the word's MSB is driven on the following launch edge.
- R4: With cfg_fmt = 1 (left-justified), the sync is active high. The MSB is driven on the same launch edge at which the sync first reads active.
- R5: With cfg_fmt = 2 (DSP-A), a one-bit active-high sync pulse precedes the MSB by one bit period.
- R6: With cfg_fmt = 3 (DSP-B), a one-bit active-high sync pulse coincides with the MSB.
- R7: cfg_wlen codes 0, 1 and 2 select 16, 20 and 24 bits, and code 3 also selects 24. The word sits in the low bits of in_data and is sent MSB first. Each slot lasts exactly one word length, and the next slot follows with no gap.
- R8: A frame carries cfg_slots_m1 + 1 slots. After the last slot, sd_out is 0 until the next frame start.
- R9: A 1 in cfg_slot_mask bit i silences slot i. The slot sends zeros and takes no word from the FIFO.
- R10: cfg_fs_inv = 1 inverts the active sync level. cfg_sck_inv = 1 moves the launch edge from falling to rising.
- R11: If a live slot starts while the FIFO is empty, the slot sends zeros and underrun goes to 1. It stays at 1 until reset.
- R12: The FIFO holds FIFO_DEPTH words and takes a word when in_valid and in_ready are both 1. in_ready is 0 while the FIFO is full.
- R13: While port_en is 0, sd_out is 0 and no word leaves the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Transmit enable; configuration is writable only while this is low |
| cfg_wr | input | 1 | Configuration capture strobe |
| cfg_fmt | input | 2 | Framing style: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| cfg_wlen | input | 2 | Word length code: 0=16, 1=20, 2 or 3=24 bits |
| cfg_sck_inv | input | 1 | 1 = data launched on the rising bit-clock edge |
| cfg_fs_inv | input | 1 | 1 = invert the active level of the sync |
| cfg_slots_m1 | input | $clog2(MAX_SLOTS) | Slots per frame minus one |
| cfg_slot_mask | input | MAX_SLOTS | Bit i set silences slot i |
| in_valid | input | 1 | Input word valid |
| in_data | input | 24 | Input word, right-aligned |
| in_ready | output | 1 | FIFO can take a word |
| sck_in | input | 1 | Bit clock from the codec |
| fs_in | input | 1 | Frame sync from the codec |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky empty-FIFO-at-slot-start flag |

## Verification
The bench drives all four framing styles and compares every bit period against a model. That comparison catches a design that puts the MSB one bit early or late, which would shift every word of an early-sync format against a coincident one. A masked slot sits between live slots, so a design that pops the FIFO in a silenced slot would send the wrong word in every slot after it. A configuration strobe pulsed while the port runs would change word length and framing in a design that accepts it. A word offered to a full FIFO, followed by a frame that drains it, shows whether the refused word leaked in or the underrun flag failed to stick.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int WORD_MAX = 24;
    localparam int BIT_W    = $clog2(WORD_MAX + 1);

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_DSPA = 2'd2,
        FMT_DSPB = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wlen;
        logic       sck_inv;
        logic       fs_inv;
    } tx_cfg_t;

    // Bits per word for a length code.
    function automatic logic [BIT_W-1:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return BIT_W'(16);
            2'd1:    return BIT_W'(20);
            default: return BIT_W'(24);
        endcase
    endfunction

    // Move a right-aligned word so that its MSB lands in the top bit.
    function automatic logic [WORD_MAX-1:0] left_align(input logic [WORD_MAX-1:0] w,
                                                       input logic [1:0] code);
        case (code)
            2'd0:    return w << 8;
            2'd1:    return w << 4;
            default: return w;
        endcase
    endfunction

    // Styles whose sync leads the first data bit by one bit period.
    function automatic logic lead_sync(input fmt_e f);
        return (f == FMT_I2S) || (f == FMT_DSPA);
    endfunction

    // Styles whose sync is active low before optional inversion.
    function automatic logic low_active(input fmt_e f);
        return (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic fs_in,
    input  logic sck_inv,
    output logic launch,
    output logic fs_lvl
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] fs_pipe;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_pipe <= '0;
            fs_pipe  <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
            fs_pipe  <= {fs_pipe[STAGES-2:0], fs_in};
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    // The sync travels through the same number of stages as the bit clock,
    // so it is read in the same cycle that the edge is seen.
    assign launch = sck_inv ? ( sck_pipe[STAGES-1] & ~sck_last)
                            : (~sck_pipe[STAGES-1] &  sck_last);
    assign fs_lvl = fs_pipe[STAGES-1];

endmodule

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

endmodule

// File: rtl/pcm_tx_engine.sv
module pcm_tx_engine
    import pcm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                port_en,
    input  tx_cfg_t             cfg,
    input  logic [SLOT_W-1:0]   slots_m1,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                launch,
    input  logic                fs_lvl,
    input  logic                fifo_empty,
    input  logic [WORD_MAX-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                sd,
    output logic                underrun
);
    logic                active_q;
    logic                pend_q;
    logic                prev_act_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [BIT_W-1:0]    bit_q;
    logic [WORD_MAX-1:0] shreg_q;

    logic                fs_act;
    logic                start_edge;
    logic                start_now;
    logic [BIT_W-1:0]    wl_m1;
    logic                last_bit;
    logic                last_slot;
    logic [SLOT_W-1:0]   next_slot;
    logic                begin_slot;
    logic                slot_live;

    always_comb begin
        fs_act     = fs_lvl ^ low_active(cfg.fmt) ^ cfg.fs_inv;
        start_edge = fs_act & ~prev_act_q;
        start_now  = lead_sync(cfg.fmt) ? pend_q : start_edge;
        wl_m1      = word_bits(cfg.wlen) - BIT_W'(1);
        last_bit   = (bit_q == wl_m1);
        last_slot  = (slot_q == slots_m1);
        next_slot  = start_now ? '0 : slot_q + SLOT_W'(1);
        begin_slot = launch & port_en &
                     (start_now | (active_q & last_bit & ~last_slot));
        slot_live  = ~slot_mask[next_slot];
        fifo_pop   = begin_slot & slot_live & ~fifo_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            pend_q     <= 1'b0;
            prev_act_q <= 1'b0;
            slot_q     <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            underrun   <= 1'b0;
        end else begin
            if (launch) prev_act_q <= fs_act;
            if (!port_en) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
                slot_q   <= '0;
                bit_q    <= '0;
                shreg_q  <= '0;
            end else if (launch) begin
                pend_q <= lead_sync(cfg.fmt) & start_edge;
                if (begin_slot) begin
                    active_q <= 1'b1;
                    slot_q   <= next_slot;
                    bit_q    <= '0;
                    shreg_q  <= fifo_pop ? left_align(fifo_data, cfg.wlen) : '0;
                    if (slot_live && fifo_empty) underrun <= 1'b1;
                end else if (active_q) begin
                    if (last_bit) begin
                        active_q <= 1'b0;
                    end else begin
                        bit_q   <= bit_q + BIT_W'(1);
                        shreg_q <= shreg_q << 1;
                    end
                end
            end
        end
    end

    assign sd = active_q & shreg_q[WORD_MAX-1];

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int MAX_SLOTS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         port_en,
    input  logic                         cfg_wr,
    input  logic [1:0]                   cfg_fmt,
    input  logic [1:0]                   cfg_wlen,
    input  logic                         cfg_sck_inv,
    input  logic                         cfg_fs_inv,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots_m1,
    input  logic [MAX_SLOTS-1:0]         cfg_slot_mask,
    input  logic                         in_valid,
    input  logic [WORD_MAX-1:0]          in_data,
    output logic                         in_ready,
    input  logic                         sck_in,
    input  logic                         fs_in,
    output logic                         sd_out,
    output logic                         underrun
);
    localparam int SLOT_W = $clog2(MAX_SLOTS);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int CFG_W  = $bits(tx_cfg_t) + SLOT_W + MAX_SLOTS;

    tx_cfg_t               cfg_q;
    logic [SLOT_W-1:0]     slots_q;
    logic [MAX_SLOTS-1:0]  mask_q;

    logic                  launch;
    logic                  fs_lvl;
    logic                  fifo_push;
    logic                  fifo_pop;
    logic                  fifo_empty;
    logic                  fifo_full;
    logic [WORD_MAX-1:0]   fifo_data;
    logic [CNT_W-1:0]      fifo_cnt;
    logic [CFG_W-1:0]      cfg_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{fmt: FMT_I2S, wlen: 2'd0, sck_inv: 1'b0, fs_inv: 1'b0};
            slots_q <= SLOT_W'(1);
            mask_q  <= '0;
        end else if (cfg_wr && !port_en) begin
            cfg_q   <= '{fmt: fmt_e'(cfg_fmt), wlen: cfg_wlen,
                         sck_inv: cfg_sck_inv, fs_inv: cfg_fs_inv};
            slots_q <= cfg_slots_m1;
            mask_q  <= cfg_slot_mask;
        end
    end

    assign cfg_state = {cfg_q, slots_q, mask_q};
    assign fifo_push = in_valid & ~fifo_full;
    assign in_ready  = ~fifo_full;

    pcm_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck_in  (sck_in),
        .fs_in   (fs_in),
        .sck_inv (cfg_q.sck_inv),
        .launch  (launch),
        .fs_lvl  (fs_lvl)
    );

    pcm_tx_fifo #(.W(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (in_data),
        .pop   (fifo_pop),
        .rdata (fifo_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    pcm_tx_engine #(.MAX_SLOTS(MAX_SLOTS)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .cfg        (cfg_q),
        .slots_m1   (slots_q),
        .slot_mask  (mask_q),
        .launch     (launch),
        .fs_lvl     (fs_lvl),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_pop   (fifo_pop),
        .sd         (sd_out),
        .underrun   (underrun)
    );

endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
    parameter int CNT_W = 3,
    parameter int CFG_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             port_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic             sd_out,
    input logic             underrun,
    input logic             fifo_pop,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic [CFG_W-1:0] cfg_state
);
    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        port_en |=> $stable(cfg_state));

    // R11
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R12
    refused_push_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && !fifo_pop) |=> $stable(fifo_cnt));

    // R13
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> !sd_out);

    // R13
    idle_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> !fifo_pop);

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sd_out    (sd_out),
    .underrun  (underrun),
    .fifo_pop  (fifo_pop),
    .fifo_cnt  (fifo_cnt),
    .cfg_state (cfg_state)
);

// File: tb/pcm_serial_tx_tb.sv
`timescale 1ns/1ps
module pcm_serial_tx_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic        cfg_sck_inv = 1'b0;
    logic        cfg_fs_inv = 1'b0;
    logic [2:0]  cfg_slots_m1 = 3'd0;
    logic [7:0]  cfg_slot_mask = 8'd0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = 24'd0;
    logic        in_ready;
    logic        sck_in = 1'b1;
    logic        fs_in = 1'b1;
    logic        sd_out;
    logic        underrun;

    always #2 clk = ~clk;

    pcm_serial_tx u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .cfg_wr(cfg_wr),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_sck_inv(cfg_sck_inv),
        .cfg_fs_inv(cfg_fs_inv), .cfg_slots_m1(cfg_slots_m1),
        .cfg_slot_mask(cfg_slot_mask), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .sck_in(sck_in), .fs_in(fs_in),
        .sd_out(sd_out), .underrun(underrun)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          b_fmt, b_wlen, b_nsl;
    bit          b_sinv, b_finv;
    logic [7:0]  b_mask;
    logic [23:0] mq[$];
    bit          exp_fs[$];
    bit          exp_sd[$];
    bit          exp_unr;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; port_en = 1'b0; in_valid = 1'b0; cfg_wr = 1'b0;
        sck_in = 1'b1; fs_in = 1'b1;
        mq.delete(); exp_fs.delete(); exp_sd.delete(); exp_unr = 1'b0;
        b_fmt = 0; b_wlen = 0; b_nsl = 2; b_sinv = 1'b0; b_finv = 1'b0; b_mask = 8'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(int fmt, int wlen, bit sinv, bit finv, int nsl, logic [7:0] mask);
        cfg_fmt = fmt[1:0]; cfg_wlen = wlen[1:0]; cfg_sck_inv = sinv;
        cfg_fs_inv = finv; cfg_slots_m1 = 3'(nsl - 1); cfg_slot_mask = mask;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        b_fmt = fmt; b_wlen = wlen; b_sinv = sinv; b_finv = finv; b_nsl = nsl; b_mask = mask;
        sck_in = ~sinv;
        fs_in = (fmt == 0) ^ finv;
        repeat (6) @(negedge clk);
    endtask

    // Driver side of the scoreboard: offer a word, record it if taken.
    task automatic push_word(logic [23:0] w);
        bit ok;
        in_valid = 1'b1; in_data = w;
        ok = in_ready;
        @(negedge clk);
        in_valid = 1'b0;
        if (ok) mq.push_back(w);
    endtask

    // Driver side: queue the sync level and expected data for every bit period.
    task automatic plan(int nframes, bit en);
        int wl;
        bit early, alow, dsp;
        int off, dbits, flen;
        logic [23:0] cur;
        wl = (b_wlen == 0) ? 16 : (b_wlen == 1) ? 20 : 24;
        early = (b_fmt == 0) || (b_fmt == 2);
        alow = (b_fmt == 0);
        dsp = (b_fmt >= 2);
        off = early ? 1 : 0;
        dbits = b_nsl * wl;
        flen = dbits + 2;
        cur = 24'd0;
        for (int i = 0; i < 2; i++) begin
            exp_fs.push_back(alow ^ b_finv); exp_sd.push_back(1'b0);
        end
        for (int f = 0; f < nframes; f++) begin
            for (int b = 0; b < flen; b++) begin
                bit act;
                bit e;
                int d;
                act = dsp ? (b == 0) : (b < wl);
                d = b - off;
                e = 1'b0;
                if (d >= 0 && d < dbits) begin
                    if (d % wl == 0) begin
                        cur = 24'd0;
                        if (en && !b_mask[d / wl]) begin
                            if (mq.size() > 0) cur = mq.pop_front();
                            else exp_unr = 1'b1;
                        end
                    end
                    e = cur[wl - 1 - (d % wl)];
                end
                exp_fs.push_back(act ^ alow ^ b_finv);
                exp_sd.push_back(e);
            end
        end
        for (int i = 0; i < 2; i++) begin
            exp_fs.push_back(alow ^ b_finv); exp_sd.push_back(1'b0);
        end
    endtask

    // Codec model and monitor: launch edge, then compare before capture edge.
    task automatic play(string req);
        while (exp_fs.size() > 0) begin
            bit f;
            bit e;
            f = exp_fs.pop_front();
            e = exp_sd.pop_front();
            sck_in = b_sinv;
            fs_in = f;
            repeat (HALF) @(negedge clk);
            check(req, sd_out, e, "serial bit");
            sck_in = ~b_sinv;
            repeat (HALF) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1", sd_out, 0, "sd_out after reset");
        check("R1", in_ready, 1, "in_ready after reset");
        check("R1", underrun, 0, "underrun after reset");

        // R3 I2S, 16-bit (R7), two slots over two frames (R8)
        set_cfg(0, 0, 0, 0, 2, 8'h00);
        push_word(24'h00A5C3); push_word(24'h00F00F);
        push_word(24'h001234); push_word(24'h008001);
        check("R12", in_ready, 0, "in_ready with full FIFO");
        port_en = 1'b1;
        plan(2, 1'b1);
        play("R3,R7,R8");
        check("R12", in_ready, 1, "in_ready after drain");
        check("R8", underrun, 0, "no underrun");

        // R4 left-justified, 24-bit (R7)
        do_reset();
        set_cfg(1, 2, 0, 0, 2, 8'h00);
        push_word(24'hC0FFEE); push_word(24'h5A5A81);
        port_en = 1'b1;
        plan(1, 1'b1);
        play("R4,R7");

        // R5 DSP-A, 20-bit, four slots with slot 1 masked (R9)
        do_reset();
        set_cfg(2, 1, 0, 0, 4, 8'h02);
        push_word(24'h0ABCDE); push_word(24'h087654); push_word(24'h0F0001);
        port_en = 1'b1;
        plan(1, 1'b1);
        play("R5,R9");
        check("R9", underrun, 0, "masked slot must not consume");

        // R6 DSP-B with both inversions (R10)
        do_reset();
        set_cfg(3, 0, 1, 1, 3, 8'h00);
        push_word(24'h00B00B); push_word(24'h007FFE); push_word(24'h00C001);
        port_en = 1'b1;
        plan(1, 1'b1);
        play("R6/R10");

        // R12 refused push, then R11 underrun on the following frame
        do_reset();
        set_cfg(1, 0, 0, 0, 4, 8'h00);
        push_word(24'h001111); push_word(24'h002222);
        push_word(24'h003333); push_word(24'h004444);
        check("R12", in_ready, 0, "in_ready when full");
        push_word(24'h00DEAD);
        port_en = 1'b1;
        plan(1, 1'b1);
        play("R12");
        check("R12", underrun, 0, "four stored words cover four slots");
        plan(1, 1'b1);
        play("R11");
        check("R11", underrun, 1, "underrun after empty slot");
        @(negedge clk); port_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R11", underrun, 1, "underrun stays set");

        // R2 configuration write while enabled is ignored (code 3 = 24 bits, R7)
        do_reset();
        set_cfg(1, 3, 0, 0, 1, 8'h00);
        push_word(24'h9ABCDE); push_word(24'h13579B);
        port_en = 1'b1;
        @(negedge clk);
        cfg_fmt = 2'd3; cfg_wlen = 2'd0; cfg_slots_m1 = 3'd3; cfg_slot_mask = 8'h01;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        plan(2, 1'b1);
        play("R2");

        // R13 disabled port sends nothing and keeps its words
        do_reset();
        set_cfg(1, 0, 0, 0, 2, 8'h00);
        push_word(24'h00ACE1); push_word(24'h006B6B);
        plan(1, 1'b0);
        play("R13");
        check("R13", underrun, 0, "no underrun while disabled");
        port_en = 1'b1;
        plan(1, 1'b1);
        play("R13");
        check("R13", underrun, 0, "words kept while disabled");

        report();
        $finish;
    end

endmodule